// File: doc/BRIEF.md
# Isochronous Receive Byte Packer

This block sits between a receive FIFO and a host-memory write port. Isochronous packets arrive as a stream of 32-bit quadlets. Each quadlet carries a kind tag (header, payload or PHY packet), an end-of-packet flag, and a count of the valid bytes in the final quadlet. The block writes the stream into a circular buffer of 32-bit words. When packing is on, a packet whose length is not a multiple of four leaves a partly filled word. The next packet's bytes continue in the free lanes of that word, and the bytes that do not fit spill into the next word address.

Byte lane k of a word is bits 8k+7:8k, with lane 0 holding the earliest byte. The 1394 side is big-endian and the host side is little-endian. Payload quadlets can therefore be byte-reversed before they reach the packer. Two control inputs turn the reversal on, and it never applies to header or PHY quadlets. A flush command forces out a partly filled word with a byte-enable mask that marks its valid lanes.

Top module: `iso_rx_packer`

## Requirements
- R1: After reset, `wr_valid` is low, `in_ready` is high, no bytes are held, and the first word is written at address 0.
- R2: A payload quadlet (`in_kind` = 1) is byte-reversed (lane k takes input lane 3-k) when `swap_off` is 0 or `swap_force` is 1. When `swap_off` is 1 and `swap_force` is 0, it passes through unchanged.
- R3: Header quadlets (`in_kind` = 0) and PHY quadlets (`in_kind` = 2) are never byte-reversed, whatever the swap controls are.
- R4: With `pack_en` = 1, the first byte of a packet goes into the lane right after the previous packet's last valid byte, in the same word. Lanes of a last quadlet at or above `in_nbytes` are discarded and never reach memory.
- R5: Bytes that do not fit in the free lanes of the current word go to the next word address, starting at lane 0.
- R6: A packet that starts with no bytes held is written word-aligned and unshifted, and each full word is written with `wr_be` = 4'b1111.
- R7: With `pack_en` = 0, the last quadlet of a packet closes its word. A partial quadlet is written with `wr_be` marking lanes 0 to `in_nbytes`-1, disabled lanes read zero, and the next packet starts a new word.
- R8: A `flush_req` accepted while N bytes (1 to 3) are held writes them with `wr_be` marking lanes 0 to N-1 and leaves nothing held. A flush with nothing held writes nothing.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_be` stay stable and `in_ready` is low.
- R10: Every written word takes the next address, and the address wraps from `BUF_WORDS`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Input quadlet accepted when high with `in_valid` |
| in_data | input | 32 | Quadlet in 1394 byte order |
| in_kind | input | 2 | 0 header, 1 payload, 2 PHY packet |
| in_last | input | 1 | Last quadlet of its packet |
| in_nbytes | input | 3 | Valid bytes (1 to 4) in the last quadlet |
| swap_off | input | 1 | Suppress payload byte reversal |
| swap_force | input | 1 | Force payload byte reversal |
| pack_en | input | 1 | Concatenate packets at byte granularity |
| flush_req | input | 1 | Write out any partly filled word |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Word address in the buffer |
| wr_data | output | 32 | Word data |
| wr_be | output | 4 | Byte enables, bit k for lane k |

## Verification
The assertions assume that `in_nbytes` lies between 1 and 4 on a last quadlet. They also assume that `pack_en` changes only while no bytes are held, because otherwise an unpacked packet could start mid-word. The directed tests drive only legal byte counts, change `pack_en` only after a word boundary or a flush, and pulse `flush_req` only while the output slot is free. Invalid lanes of partial quadlets carry garbage bytes, so any leak into a later word shows up in the data comparison.

// File: rtl/iso_pack_pkg.sv
package iso_pack_pkg;

  typedef enum logic [1:0] {
    QK_HDR = 2'd0,
    QK_PAY = 2'd1,
    QK_PHY = 2'd2
  } qkind_e;

  // Lanes 0..n-1 enabled; n of 4 or more gives all lanes.
  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd0:    lane_mask = 4'b0000;
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      3'd3:    lane_mask = 4'b0111;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/iso_swap_lane.sv
module iso_swap_lane
  import iso_pack_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic [8*NBYTES-1:0] d_in,
  input  logic [1:0]          kind,
  input  logic                swap_off,
  input  logic                swap_force,
  output logic [8*NBYTES-1:0] d_out
);

  logic [8*NBYTES-1:0] rev;
  logic                swap_on;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_rev
      assign rev[8*gi +: 8] = d_in[8*(NBYTES-1-gi) +: 8];
    end
  endgenerate

  // Only payload quadlets are candidates for reversal.
  assign swap_on = (kind == QK_PAY) && (!swap_off || swap_force);
  assign d_out   = swap_on ? rev : d_in;

endmodule

// File: rtl/iso_lane_packer.sv
module iso_lane_packer #(
  parameter int NBYTES = 4,
  localparam int DW = 8*NBYTES,
  localparam int OW = $clog2(NBYTES)
) (
  input  logic [DW-1:0] hold,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] q,
  input  logic [3:0]    q_lanes,
  output logic [DW-1:0] lo_word,
  output logic [DW-1:0] hi_word
);

  logic [DW-1:0]   q_masked;
  logic [2*DW-1:0] merged;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_mask
      assign q_masked[8*gi +: 8] = q_lanes[gi] ? q[8*gi +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    merged  = {{DW{1'b0}}, hold} | ({{DW{1'b0}}, q_masked} << (8*off));
    lo_word = merged[DW-1:0];
    hi_word = merged[2*DW-1:DW];
  end

endmodule

// File: rtl/iso_wr_addr.sv
module iso_wr_addr #(
  parameter int ADDR_W    = 10,
  parameter int BUF_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BUF_WORDS - 1);

  logic [ADDR_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (step) cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_n;
  end

  assign addr = cnt_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < BUF_WORDS); // R10

endmodule

// File: rtl/iso_rx_packer.sv
module iso_rx_packer
  import iso_pack_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BUF_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic [1:0]        in_kind,
  input  logic              in_last,
  input  logic [2:0]        in_nbytes,
  input  logic              swap_off,
  input  logic              swap_force,
  input  logic              pack_en,
  input  logic              flush_req,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be
);

  localparam int NBYTES = 4;
  localparam int DW     = 8*NBYTES;

  // Holding register and lane offset
  logic [DW-1:0] hold_q, hold_n;
  logic [1:0]    off_q, off_n;

  // Output slot
  logic              wv_q, wv_n;
  logic [DW-1:0]     wd_q, wd_n;
  logic [3:0]        wb_q, wb_n;
  logic [ADDR_W-1:0] wa_q, wa_n;

  logic              out_free, accept, emit;
  logic [DW-1:0]     e_data;
  logic [3:0]        e_be;
  logic [2:0]        nb_eff, total;
  logic [3:0]        q_lanes;
  logic [DW-1:0]     q_host, lo_word, hi_word;
  logic [ADDR_W-1:0] cur_addr;

  assign out_free = !wv_q || wr_ready;
  assign in_ready = out_free && !flush_req;
  assign accept   = in_valid && in_ready;
  assign nb_eff   = in_last ? in_nbytes : 3'd4;
  assign q_lanes  = lane_mask(nb_eff);
  assign total    = {1'b0, off_q} + nb_eff;

  iso_swap_lane #(.NBYTES(NBYTES)) u_swap (
    .d_in       (in_data),
    .kind       (in_kind),
    .swap_off   (swap_off),
    .swap_force (swap_force),
    .d_out      (q_host)
  );

  iso_lane_packer #(.NBYTES(NBYTES)) u_pack (
    .hold    (hold_q),
    .off     (off_q),
    .q       (q_host),
    .q_lanes (q_lanes),
    .lo_word (lo_word),
    .hi_word (hi_word)
  );

  iso_wr_addr #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (emit),
    .addr  (cur_addr)
  );

  // Next state of the packer
  always_comb begin
    hold_n = hold_q;
    off_n  = off_q;
    emit   = 1'b0;
    e_data = lo_word;
    e_be   = 4'b1111;
    if (flush_req && out_free) begin
      if (off_q != 2'd0) begin
        emit   = 1'b1;
        e_data = hold_q;
        e_be   = lane_mask({1'b0, off_q});
        hold_n = '0;
        off_n  = 2'd0;
      end
    end else if (accept) begin
      if (total >= 3'd4) begin
        emit   = 1'b1;
        hold_n = hi_word;
        off_n  = total[1:0];
      end else if (!pack_en && in_last) begin
        emit   = 1'b1;
        e_be   = lane_mask(total);
        hold_n = '0;
        off_n  = 2'd0;
      end else begin
        hold_n = lo_word;
        off_n  = total[1:0];
      end
    end
  end

  // Next state of the output slot
  always_comb begin
    wv_n = wv_q;
    wd_n = wd_q;
    wb_n = wb_q;
    wa_n = wa_q;
    if (emit) begin
      wv_n = 1'b1;
      wd_n = e_data;
      wb_n = e_be;
      wa_n = cur_addr;
    end else if (wr_ready) begin
      wv_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      off_q  <= 2'd0;
    end else if (accept || flush_req) begin
      hold_q <= hold_n;
      off_q  <= off_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      wd_q <= '0;
      wb_q <= '0;
      wa_q <= '0;
    end else if (out_free) begin
      wv_q <= wv_n;
      wd_q <= wd_n;
      wb_q <= wb_n;
      wa_q <= wa_n;
    end
  end

  assign wr_valid = wv_q;
  assign wr_data  = wd_q;
  assign wr_be    = wb_q;
  assign wr_addr  = wa_q;

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(wr_be)); // R9

  AST_BE_FROM_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be == 4'b0001 || wr_be == 4'b0011 || wr_be == 4'b0111 || wr_be == 4'b1111)); // R8

  AST_NOPACK_REALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_en && accept && in_last |=> off_q == 2'd0); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && out_free |=> off_q == 2'd0); // R8

endmodule

// File: tb/tb_iso_rx_packer.sv
module tb_iso_rx_packer;

  localparam int AW  = 3;
  localparam int BUF = 8;

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_last;
  logic [31:0] in_data;
  logic [1:0]  in_kind;
  logic [2:0]  in_nbytes;
  logic        swap_off, swap_force, pack_en, flush_req;
  logic        wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;

  int checks = 0;
  int errors = 0;
  int eaddr  = 0;

  logic [AW-1:0] qa[$];
  logic [31:0]   qd[$];
  logic [3:0]    qb[$];
  string         qt[$];

  iso_rx_packer #(.ADDR_W(AW), .BUF_WORDS(BUF)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_kind(in_kind), .in_last(in_last), .in_nbytes(in_nbytes),
    .swap_off(swap_off), .swap_force(swap_force), .pack_en(pack_en),
    .flush_req(flush_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic expect_wr(input logic [31:0] d, input logic [3:0] be, input string tag);
    qa.push_back(AW'(eaddr));
    qd.push_back(d);
    qb.push_back(be);
    qt.push_back(tag);
    eaddr = (eaddr + 1) % BUF;
  endtask

  // Write monitor: compares each accepted write with the next expected one
  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (qa.size() == 0) begin
        check(1'b0, "R8", $sformatf("unexpected write addr=%0d data=%h be=%b, expected none",
                                    wr_addr, wr_data, wr_be));
      end else begin
        logic [AW-1:0] ea;
        logic [31:0]   ed;
        logic [3:0]    eb;
        string         et;
        ea = qa.pop_front(); ed = qd.pop_front(); eb = qb.pop_front(); et = qt.pop_front();
        check(wr_addr == ea && wr_data == ed && wr_be == eb, et,
              $sformatf("write addr=%0d data=%h be=%b, expected addr=%0d data=%h be=%b",
                        wr_addr, wr_data, wr_be, ea, ed, eb));
      end
    end
  end

  task automatic send(input logic [31:0] d, input logic [1:0] k, input bit last, input logic [2:0] nb);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_kind = k; in_last = last; in_nbytes = nb;
    do begin
      @(posedge clk);
      acc = in_ready;
    end while (!acc);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    bit done;
    @(negedge clk);
    flush_req = 1'b1;
    do begin
      @(posedge clk);
      done = !wr_valid || wr_ready;
    end while (!done);
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  task automatic drained(input string tag);
    repeat (6) @(negedge clk);
    check(qa.size() == 0, tag, $sformatf("%0d writes missing, expected 0", qa.size()));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(wr_valid == 1'b0 && in_ready == 1'b1, "R1",
          $sformatf("wr_valid=%b in_ready=%b, expected 0 1", wr_valid, in_ready));
  endtask

  task automatic t_swap_aligned();
    swap_off = 1'b0; swap_force = 1'b0; pack_en = 1'b1;
    expect_wr(32'h44332211, 4'hF, "R1");
    expect_wr(32'h88776655, 4'hF, "R6");
    send(32'h11223344, 2'd1, 1'b0, 3'd4);
    send(32'h55667788, 2'd1, 1'b1, 3'd4);
    drained("R2");
  endtask

  task automatic t_swap_kinds();
    swap_off = 1'b0; swap_force = 1'b0;
    expect_wr(32'hA1B2C3D4, 4'hF, "R3");
    send(32'hA1B2C3D4, 2'd0, 1'b1, 3'd4);
    expect_wr(32'h0F1E2D3C, 4'hF, "R3");
    send(32'h0F1E2D3C, 2'd2, 1'b1, 3'd4);
    swap_off = 1'b1; swap_force = 1'b1;
    expect_wr(32'h04030201, 4'hF, "R2");
    send(32'h01020304, 2'd1, 1'b1, 3'd4);
    swap_force = 1'b0;
    expect_wr(32'hCAFEF00D, 4'hF, "R2");
    send(32'hCAFEF00D, 2'd1, 1'b1, 3'd4);
    drained("R3");
  endtask

  task automatic t_pack_spill();
    swap_off = 1'b1; swap_force = 1'b0; pack_en = 1'b1;
    send(32'hEEEEEEAA, 2'd1, 1'b1, 3'd1);      // 1 byte held
    drained("R4");                              // nothing written yet
    expect_wr(32'h332211AA, 4'hF, "R4");
    send(32'h44332211, 2'd1, 1'b0, 3'd4);      // byte 0x44 spills
    send(32'hEEEE6655, 2'd1, 1'b1, 3'd2);      // 3 bytes held
    expect_wr(32'hF1665544, 4'hF, "R5");
    send(32'hEEF3F2F1, 2'd1, 1'b1, 3'd3);      // 2 bytes held, address wraps next
    expect_wr(32'h0000F3F2, 4'b0011, "R10");
    do_flush();
    drained("R8");
    do_flush();                                 // nothing held: no write
    drained("R8");
  endtask

  task automatic t_nopack();
    pack_en = 1'b0; swap_off = 1'b1; swap_force = 1'b0;
    expect_wr(32'h0000BB0A, 4'b0011, "R7");
    send(32'hEE00BB0A, 2'd1, 1'b1, 3'd2);
    expect_wr(32'h11111111, 4'hF, "R7");
    send(32'h11111111, 2'd1, 1'b1, 3'd4);
    drained("R7");
    pack_en = 1'b1;
  endtask

  task automatic t_backpressure();
    wr_ready = 1'b0;
    expect_wr(32'h5A5A0001, 4'hF, "R9");
    send(32'h5A5A0001, 2'd1, 1'b1, 3'd4);
    repeat (4) @(negedge clk);
    check(wr_valid && !in_ready && wr_data == 32'h5A5A0001 && wr_addr == 3'd3, "R9",
          $sformatf("valid=%b ready=%b data=%h addr=%0d, expected 1 0 5a5a0001 3",
                    wr_valid, in_ready, wr_data, wr_addr));
    wr_ready = 1'b1;
    drained("R9");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_kind = '0; in_last = 1'b0;
    in_nbytes = 3'd4; swap_off = 1'b1; swap_force = 1'b0; pack_en = 1'b1;
    flush_req = 1'b0; wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_swap_aligned();
    t_swap_kinds();
    t_pack_spill();
    t_nopack();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule